// File: doc/BRIEF.md
# Interrupt-Activated Descriptor Fetch Sequencer

This block sits between a set of interrupt-driven activation requests and a transfer engine. Each request line belongs to one interrupt vector number. When requests are pending, the sequencer picks the lowest-numbered one. It reads that vector's 32-bit pointer from a table in memory and fetches the transfer descriptor stored at that pointer. It then passes the descriptor to the engine over a start/done handshake and writes the descriptor the engine returns back to the same memory words. After each descriptor it follows the chain setting of the descriptor to decide whether to continue with the next descriptor in memory or to stop. At the end of the activation it decides whether the source interrupt goes on to the CPU or is consumed.

Memory is reached through a single-beat port. The sequencer holds the request, write flag, address and write data steady until an acknowledge arrives, and read data is taken in the acknowledge cycle. A descriptor is `DESC_WORDS` consecutive 32-bit words. Word 0 is the control word, and the last word holds the 16-bit remaining count in bits [15:0]. The engine owns the count arithmetic and reports whether the transfer it just ran was the final one.

Once a normal-mode descriptor has completed its final transfer, the sequencer marks its source as exhausted. From then on, requests from that source go straight to the CPU and start no transfer.

Top module: `irq_xfer_seq`

## Requirements
- R1: The first memory access of an activation for vector v is a read at `tbl_base_i + 4*v`. The value read is the descriptor pointer.
- R2: When several non-exhausted requests are pending, the lowest vector number is served first.
- R3: Each descriptor is handled in a fixed order. First come `DESC_WORDS` reads at pointer, pointer+4, and so on. Then one `eng_start_o` pulse. After `eng_done_i`, the words from `eng_desc_i` are written back to the same addresses in the same order. The memory request, write flag and address stay stable until `mem_ack_i`.
- R4: Control word bits [3:2] = 1 (chain on each) always continue with the descriptor at pointer + 4*`DESC_WORDS`.
- R5: Control word bits [3:2] = 2 (chain on end) continue with the next descriptor only when `eng_last_i` was high for that descriptor.
- R6: Control word bits [3:2] = 0 end the activation after that descriptor's write-back.
- R7: At the end of an activation, `cpu_irq_o[v]` pulses for one cycle only if the final descriptor has control bit 4 (interrupt on each) set or its engine run reported last. Otherwise no pulse is raised.
- R8: When a descriptor with control bits [1:0] = 0 (normal mode) ends an activation with last reported, vector v becomes exhausted. Every later request from v gives a `cpu_irq_o[v]` pulse with no memory access and no busy.
- R9: Requests that arrive during an activation are held and served afterwards in priority order. This includes a repeat request from the vector being served.
- R10: `busy_o` is low in the arbitration cycle, is high from the next cycle through the final write-back acknowledge, and is high during every memory access.
- R11: During and right after reset, `busy_o`, `mem_req_o`, `eng_start_o` and `cpu_irq_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | NUM_SRC | Activation request pulses, one per vector |
| tbl_base_i | input | AW | Byte address of the pointer table |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | AW | Byte address, word aligned |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid with acknowledge |
| mem_ack_i | input | 1 | Access complete |
| eng_start_o | output | 1 | One-cycle start to the transfer engine |
| eng_desc_o | output | 32*DESC_WORDS | Descriptor handed to the engine |
| eng_done_i | input | 1 | Engine finished one run |
| eng_desc_i | input | 32*DESC_WORDS | Updated descriptor from the engine |
| eng_last_i | input | 1 | The run was the final transfer of the descriptor |
| cpu_irq_o | output | NUM_SRC | One-cycle interrupt pulses forwarded to the CPU |
| busy_o | output | 1 | Activation in progress |

## Verification
The bench builds the block with eight vectors, four-word descriptors and a 32-bit address. This gives room for a three-descriptor chain, simultaneous requests on two vectors, and a request that arrives mid-activation on both the vector being served and another one. A non-zero table base is used, so the table-index arithmetic is visible in the observed addresses. The bench's engine model decrements the count and reloads it in repeat mode. This brings the final-transfer paths within reach: chain-on-end continuation, interrupt forwarding on last, and exhaustion of a normal-mode vector.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_VEC, ST_FETCH, ST_START, ST_RUN, ST_WB
  } seq_state_e;

  typedef enum logic [1:0] {
    CH_NONE = 2'd0, CH_EACH = 2'd1, CH_END = 2'd2
  } chain_e;

  localparam logic [1:0] MODE_NORMAL = 2'd0;
  localparam int CTRL_MODE_LSB  = 0;
  localparam int CTRL_CHAIN_LSB = 2;
  localparam int CTRL_IRQ_EACH  = 4;
endpackage

// File: rtl/irq_seq_arb.sv
module irq_seq_arb #(
  parameter int NUM_SRC = 8,
  localparam int IW = $clog2(NUM_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] req_i,
  output logic               valid_o,
  output logic [IW-1:0]      idx_o
);
  // lowest index wins
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        valid_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end

  a_r2_grant_in_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> req_i[idx_o]);
endmodule

// File: rtl/irq_seq_pend.sv
module irq_seq_pend #(
  parameter int NUM_SRC = 8,
  localparam int IW = $clog2(NUM_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               busy_i,
  input  logic               done_i,
  input  logic               fire_i,
  input  logic               exhaust_i,
  input  logic [IW-1:0]      cur_i,
  output logic [NUM_SRC-1:0] arb_req_o,
  output logic [NUM_SRC-1:0] cpu_irq_o
);
  logic [NUM_SRC-1:0] pend_q, exh_q, irq_q, cur_oh, fwd, clr;
  logic again_q;

  assign cur_oh    = NUM_SRC'(1) << cur_i;
  assign fwd       = pend_q & exh_q;            // exhausted: straight to CPU
  assign clr       = fwd | (done_i ? cur_oh : '0);
  assign arb_req_o = pend_q & ~exh_q;
  assign cpu_irq_o = irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= '0;
      exh_q   <= '0;
      irq_q   <= '0;
      again_q <= 1'b0;
    end else begin
      pend_q <= (pend_q & ~clr) | req_i | ((done_i && again_q) ? cur_oh : '0);
      exh_q  <= exh_q | (exhaust_i ? cur_oh : '0);
      irq_q  <= fwd | (fire_i ? cur_oh : '0);
      if (done_i)                          again_q <= 1'b0;
      else if (busy_i && |(req_i & cur_oh)) again_q <= 1'b1;
    end
  end

  a_r9_pend_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !done_i) |=> |(pend_q & cur_oh));
endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
  import irq_seq_pkg::*;
#(
  parameter int AW         = 32,
  parameter int NUM_SRC    = 8,
  parameter int DESC_WORDS = 4,
  localparam int IW  = $clog2(NUM_SRC),
  localparam int WIW = $clog2(DESC_WORDS),
  localparam int DESC_BYTES = 4 * DESC_WORDS
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [AW-1:0]           tbl_base_i,
  input  logic                    gnt_valid_i,
  input  logic [IW-1:0]           gnt_idx_i,
  output logic                    mem_req_o,
  output logic                    mem_we_o,
  output logic [AW-1:0]           mem_addr_o,
  output logic [31:0]             mem_wdata_o,
  input  logic [31:0]             mem_rdata_i,
  input  logic                    mem_ack_i,
  output logic                    eng_start_o,
  output logic [32*DESC_WORDS-1:0] eng_desc_o,
  input  logic                    eng_done_i,
  input  logic [32*DESC_WORDS-1:0] eng_desc_i,
  input  logic                    eng_last_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic                    fire_o,
  output logic                    exhaust_o,
  output logic [IW-1:0]           cur_o
);
  seq_state_e state_q;
  logic [IW-1:0]  cur_q;
  logic [AW-1:0]  ptr_q;
  logic [WIW-1:0] widx_q;
  logic [DESC_WORDS-1:0][31:0] desc_q;
  logic last_q, last_word, cont;
  chain_e chain;

  assign last_word   = widx_q == WIW'(DESC_WORDS - 1);
  assign chain       = chain_e'(desc_q[0][CTRL_CHAIN_LSB +: 2]);
  assign cont        = (chain == CH_EACH) || (chain == CH_END && last_q);

  assign busy_o      = state_q != ST_IDLE;
  assign mem_req_o   = state_q inside {ST_VEC, ST_FETCH, ST_WB};
  assign mem_we_o    = state_q == ST_WB;
  assign mem_addr_o  = (state_q == ST_VEC) ? tbl_base_i + (AW'(cur_q) << 2)
                                           : ptr_q + (AW'(widx_q) << 2);
  assign mem_wdata_o = desc_q[widx_q];
  assign eng_start_o = state_q == ST_START;
  assign eng_desc_o  = desc_q;
  assign cur_o       = cur_q;

  assign done_o    = state_q == ST_WB && mem_ack_i && last_word && !cont;
  assign fire_o    = done_o && (desc_q[0][CTRL_IRQ_EACH] || last_q);
  assign exhaust_o = done_o && last_q && desc_q[0][CTRL_MODE_LSB +: 2] == MODE_NORMAL;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      ptr_q   <= '0;
      widx_q  <= '0;
      desc_q  <= '0;
      last_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (gnt_valid_i) begin
          cur_q   <= gnt_idx_i;
          state_q <= ST_VEC;
        end
        ST_VEC: if (mem_ack_i) begin
          ptr_q   <= mem_rdata_i;
          widx_q  <= '0;
          state_q <= ST_FETCH;
        end
        ST_FETCH: if (mem_ack_i) begin
          desc_q[widx_q] <= mem_rdata_i;
          if (last_word) begin
            widx_q  <= '0;
            state_q <= ST_START;
          end else widx_q <= widx_q + 1'b1;
        end
        ST_START: state_q <= ST_RUN;
        ST_RUN: if (eng_done_i) begin
          desc_q  <= eng_desc_i;
          last_q  <= eng_last_i;
          widx_q  <= '0;
          state_q <= ST_WB;
        end
        ST_WB: if (mem_ack_i) begin
          if (last_word) begin
            widx_q <= '0;
            if (cont) begin
              ptr_q   <= ptr_q + AW'(DESC_BYTES);
              state_q <= ST_FETCH;
            end else state_q <= ST_IDLE;
          end else widx_q <= widx_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r3_mem_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));
  a_r3_start_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o |=> !eng_start_o);
  a_r10_idle_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
  a_r1_vec_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (mem_req_o && !mem_we_o));
endmodule

// File: rtl/irq_xfer_seq.sv
module irq_xfer_seq #(
  parameter int AW         = 32,
  parameter int NUM_SRC    = 8,
  parameter int DESC_WORDS = 4,
  localparam int IW = $clog2(NUM_SRC)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_SRC-1:0]       req_i,
  input  logic [AW-1:0]            tbl_base_i,
  output logic                     mem_req_o,
  output logic                     mem_we_o,
  output logic [AW-1:0]            mem_addr_o,
  output logic [31:0]              mem_wdata_o,
  input  logic [31:0]              mem_rdata_i,
  input  logic                     mem_ack_i,
  output logic                     eng_start_o,
  output logic [32*DESC_WORDS-1:0] eng_desc_o,
  input  logic                     eng_done_i,
  input  logic [32*DESC_WORDS-1:0] eng_desc_i,
  input  logic                     eng_last_i,
  output logic [NUM_SRC-1:0]       cpu_irq_o,
  output logic                     busy_o
);
  logic [NUM_SRC-1:0] arb_req;
  logic gnt_valid, done, fire, exhaust;
  logic [IW-1:0] gnt_idx, cur;

  irq_seq_arb #(.NUM_SRC(NUM_SRC)) u_arb (
    .clk_i, .rst_ni, .req_i(arb_req), .valid_o(gnt_valid), .idx_o(gnt_idx)
  );

  irq_seq_pend #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk_i, .rst_ni, .req_i, .busy_i(busy_o), .done_i(done), .fire_i(fire),
    .exhaust_i(exhaust), .cur_i(cur), .arb_req_o(arb_req), .cpu_irq_o
  );

  irq_seq_fsm #(.AW(AW), .NUM_SRC(NUM_SRC), .DESC_WORDS(DESC_WORDS)) u_fsm (
    .clk_i, .rst_ni, .tbl_base_i, .gnt_valid_i(gnt_valid), .gnt_idx_i(gnt_idx),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_rdata_i, .mem_ack_i,
    .eng_start_o, .eng_desc_o, .eng_done_i, .eng_desc_i, .eng_last_i,
    .busy_o, .done_o(done), .fire_o(fire), .exhaust_o(exhaust), .cur_o(cur)
  );
endmodule

// File: tb/irq_xfer_seq_bench.sv
module irq_xfer_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 8;
  localparam int DW = 4;
  localparam logic [31:0] BASE = 32'h20;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [NS-1:0] req_i = '0;
  logic mem_req_o, mem_we_o, eng_start_o, busy_o;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic [31:0] mem_rdata_i = '0;
  logic mem_ack_i = 1'b0;
  logic [32*DW-1:0] eng_desc_o;
  logic [32*DW-1:0] eng_desc_i = '0;
  logic eng_done_i = 1'b0, eng_last_i = 1'b0;
  logic [NS-1:0] cpu_irq_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  irq_xfer_seq #(.AW(32), .NUM_SRC(NS), .DESC_WORDS(DW)) u_irq_xfer_seq (
    .clk_i, .rst_ni, .req_i, .tbl_base_i(BASE), .mem_req_o, .mem_we_o,
    .mem_addr_o, .mem_wdata_o, .mem_rdata_i, .mem_ack_i, .eng_start_o,
    .eng_desc_o, .eng_done_i, .eng_desc_i, .eng_last_i, .cpu_irq_o, .busy_o
  );

  // memory model, one-cycle acknowledge
  logic [31:0] mem [256];
  logic tb_we = 1'b0;
  logic [7:0] tb_a = '0;
  logic [31:0] tb_d = '0;
  always @(posedge clk_i) begin
    if (tb_we) mem[tb_a] <= tb_d;
    mem_ack_i <= 1'b0;
    if (mem_req_o && !mem_ack_i) begin
      mem_ack_i   <= 1'b1;
      mem_rdata_i <= mem[mem_addr_o[9:2]];
      if (mem_we_o) mem[mem_addr_o[9:2]] <= mem_wdata_o;
    end
  end

  // engine model: count-1 in [15:0], reload from [31:16] in repeat mode, word1 += 4
  function automatic logic [32*DW+0:0] eng_update(input logic [32*DW-1:0] d);
    logic [DW-1:0][31:0] w;
    logic [15:0] c;
    logic last;
    w = d;
    c = w[DW-1][15:0] - 16'd1;
    last = (c == 16'd0);
    if (last && w[0][1:0] == 2'd1) c = w[DW-1][31:16];
    w[DW-1][15:0] = c;
    w[1] = w[1] + 32'd4;
    return {last, w};
  endfunction

  int ecnt = 0;
  always @(posedge clk_i) begin
    eng_done_i <= 1'b0;
    if (eng_start_o) begin
      ecnt <= 2;
      {eng_last_i, eng_desc_i} <= eng_update(eng_desc_o);
    end else if (ecnt != 0) begin
      ecnt <= ecnt - 1;
      if (ecnt == 1) eng_done_i <= 1'b1;
    end
  end

  // monitors
  int nlog = 0, busy_bad = 0, busy_cyc = 0;
  logic [31:0] log_addr [512];
  logic log_we [512];
  int irq_cnt [NS];
  initial for (int i = 0; i < NS; i++) irq_cnt[i] = 0;
  always @(negedge clk_i) begin
    if (mem_req_o && mem_ack_i) begin
      log_addr[nlog] = mem_addr_o;
      log_we[nlog]   = mem_we_o;
      nlog++;
      if (!busy_o) busy_bad++;
    end
    if (busy_o) busy_cyc++;
    for (int i = 0; i < NS; i++) if (cpu_irq_o[i]) irq_cnt[i]++;
  end

  int tests = 0, fails = 0;
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int dw(input int s, input int k, input int w);
    return 64 + 16*s + 4*k + w;
  endfunction

  task automatic poke(input int a, input logic [31:0] d);
    tb_a = 8'(a); tb_d = d; tb_we = 1'b1;
    @(negedge clk_i);
    tb_we = 1'b0;
  endtask

  task automatic put_desc(input int s, input int k, input logic [31:0] ctrl, input logic [31:0] w3);
    poke(dw(s, k, 0), ctrl);
    poke(dw(s, k, 1), 32'h0);
    poke(dw(s, k, 2), 32'h0);
    poke(dw(s, k, 3), w3);
  endtask

  task automatic pulse(input logic [NS-1:0] v);
    req_i = v;
    @(negedge clk_i);
    req_i = '0;
  endtask

  task automatic settle();
    int quiet = 0;
    while (quiet < 4) begin
      @(negedge clk_i);
      if (busy_o) quiet = 0; else quiet++;
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  // {src, ctrl, count word, expected irq, expected count}
  localparam logic [71:0] TV [6] = '{
    {8'd3, 8'h00, 32'h0000_0003, 8'd0, 16'd2},
    {8'd1, 8'h10, 32'h0000_0005, 8'd1, 16'd4},
    {8'd2, 8'h01, 32'h0004_0001, 8'd1, 16'd4},
    {8'd4, 8'h02, 32'h0000_0002, 8'd0, 16'd1},
    {8'd6, 8'h00, 32'h0000_0001, 8'd1, 16'd0},
    {8'd7, 8'h11, 32'h0000_0003, 8'd1, 16'd2}
  };

  initial begin
    repeat (200000) @(posedge clk_i);
    tests++; fails++;
    $display("FAIL R10 watchdog act=busy exp=idle");
    summary();
    $finish;
  end

  initial begin
    int nb, ib, bb;
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk_i);
    chk("R11 busy in reset", 32'(busy_o), 0);
    chk("R11 mem_req in reset", 32'(mem_req_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R11 busy after reset", 32'(busy_o), 0);
    chk("R11 start after reset", 32'(eng_start_o), 0);
    chk("R11 irq after reset", 32'(cpu_irq_o), 0);
    for (int s = 0; s < NS; s++) poke(int'(BASE[9:2]) + s, 32'h100 + 32'(s) * 32'h40);

    // table-driven single activations
    foreach (TV[i]) begin
      int s;
      s = int'(TV[i][71:64]);
      put_desc(s, 0, 32'(TV[i][63:56]), TV[i][55:24]);
      nb = nlog; ib = irq_cnt[s];
      pulse(NS'(1) << s);
      chk("R10 low in arbitration cycle", 32'(busy_o), 0);
      @(negedge clk_i);
      chk("R10 high after grant", 32'(busy_o), 1);
      settle();
      chk("R1 table read address", log_addr[nb], BASE + 32'(4*s));
      chk("R3 first descriptor read", log_addr[nb+1], 32'h100 + 32'(s) * 32'h40);
      chk("R3 access count", 32'(nlog - nb), 9);
      chk("R3 last write-back", {log_addr[nb+8][30:0], log_we[nb+8]},
          {31'(32'h10C + 32'(s) * 32'h40), 1'b1});
      chk("R3 count written back", mem[dw(s, 0, 3)][15:0], 32'(TV[i][15:0]));
      chk("R3 word1 written back", mem[dw(s, 0, 1)], 4);
      chk("R7 irq forwarding", 32'(irq_cnt[s] - ib), 32'(TV[i][23:16]));
    end
    chk("R10 busy during accesses", 32'(busy_bad), 0);

    // R8: vector 6 exhausted by its normal-mode last transfer above
    nb = nlog; ib = irq_cnt[6]; bb = busy_cyc;
    pulse(NS'(1) << 6);
    settle();
    chk("R8 forwarded irq", 32'(irq_cnt[6] - ib), 1);
    chk("R8 no memory access", 32'(nlog - nb), 0);
    chk("R8 no busy", 32'(busy_cyc - bb), 0);

    // R4/R5/R6 chain: each -> end(last) -> none(not last)
    put_desc(0, 0, 32'h04, 32'h3);
    put_desc(0, 1, 32'h08, 32'h1);
    put_desc(0, 2, 32'h00, 32'h5);
    nb = nlog; ib = irq_cnt[0];
    pulse(NS'(1));
    settle();
    chk("R4 R5 three descriptors run", 32'(nlog - nb), 25);
    chk("R4 next descriptor address", log_addr[nb+9], 32'h110);
    chk("R5 continue after last", log_addr[nb+17], 32'h120);
    chk("R6 third count", mem[dw(0, 2, 3)][15:0], 4);
    chk("R7 no irq on silent end", 32'(irq_cnt[0] - ib), 0);

    // R5/R6: end-chain without last stops
    put_desc(0, 1, 32'h08, 32'h2);
    nb = nlog;
    pulse(NS'(1));
    settle();
    chk("R5 stop when not last", 32'(nlog - nb), 17);
    chk("R6 untouched third", mem[dw(0, 2, 3)][15:0], 4);

    // R2 priority
    put_desc(1, 0, 32'h00, 32'h10);
    put_desc(4, 0, 32'h02, 32'h10);
    nb = nlog;
    pulse((NS'(1) << 4) | (NS'(1) << 1));
    settle();
    chk("R2 lower vector first", log_addr[nb], BASE + 4);
    chk("R2 higher vector second", log_addr[nb+9], BASE + 16);

    // R9 requests during an activation
    put_desc(2, 0, 32'h01, 32'h0004_0003);
    put_desc(3, 0, 32'h00, 32'h10);
    nb = nlog;
    pulse(NS'(1) << 2);
    repeat (3) @(negedge clk_i);
    pulse((NS'(1) << 3) | (NS'(1) << 2));
    settle();
    chk("R9 three activations", 32'(nlog - nb), 27);
    chk("R9 repeat request served", log_addr[nb+9], BASE + 8);
    chk("R9 other request last", log_addr[nb+18], BASE + 12);
    chk("R9 repeat count", mem[dw(2, 0, 3)][15:0], 1);

    summary();
    $finish;
  end
endmodule